// File: doc/BRIEF.md
# Segment Offset Translator

This block maps a segment-relative offset to a 32-bit linear address. It keeps a small bank of segment descriptors. Each descriptor holds a 32-bit base, a 16-bit limit and a granularity flag. A write port loads one descriptor at a time. Each lookup names a descriptor slot and gives an offset. The block adds the base to the offset. It also tests the offset against the highest legal value for that segment. The result is registered and appears one cycle later, either as a valid address or as a fault.

The granularity flag selects the unit of the limit. When the flag is clear, the limit counts single bytes. When the flag is set, the limit counts 4096-byte pages, and the highest legal offset becomes `(limit << 12) | 0xFFF`. Only six descriptor slots exist, so a lookup can reach at most six segments at once. A slot that has not been written since reset faults on every lookup. A slot index that does not exist also faults. Fetching descriptors from memory, privilege checks and paging are handled elsewhere.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst_ni` is low and after reset release, `rsp_valid_o`, `rsp_fault_o` and `rsp_addr_o` are all zero, and every descriptor slot is marked not loaded.
- R2: A lookup presented with `req_valid_i` high at a rising edge is answered in the cycle after that edge. Exactly one of `rsp_valid_o` and `rsp_fault_o` is high in that cycle. Both are low in a cycle that follows an edge with no lookup.
- R3: For a lookup that does not fault, `rsp_addr_o` equals the slot base plus the offset, taken modulo 2^32.
- R4: With the granularity flag clear, an offset equal to the limit is accepted, and any larger offset faults.
- R5: With the granularity flag set, offsets up to and including `(limit << 12) | 0xFFF` are accepted, and any larger offset faults.
- R6: A fault forces `rsp_valid_o` low and `rsp_addr_o` to zero.
- R7: A lookup to a slot that has not been written since reset faults.
- R8: A lookup with a slot index of 6 or higher (the codes 6 and 7 of the 3-bit index) faults.
- R9: A descriptor write takes effect for lookups from the next edge onward. A lookup at the same edge as a write to its own slot uses the previous contents.
- R10: A descriptor write to a slot index of 6 or higher has no effect: lookups with that index still fault, and all six real slots keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable for a descriptor slot |
| wr_idx_i | input | 3 | Slot index to write |
| wr_base_i | input | 32 | Base to write |
| wr_limit_i | input | 16 | Limit to write |
| wr_gran_i | input | 1 | Granularity to write: 0 for bytes, 1 for 4 KB units |
| req_valid_i | input | 1 | Lookup request |
| req_idx_i | input | 3 | Slot index of the lookup |
| req_ofs_i | input | 32 | Offset within the segment |
| rsp_valid_o | output | 1 | The registered lookup produced an address |
| rsp_fault_o | output | 1 | The registered lookup faulted |
| rsp_addr_o | output | 32 | Linear address, zero when there is no valid result |

## Verification
The bench builds the block with its default parameters: six slots, a 3-bit index and a granularity shift of 12. The 3-bit index leaves codes 6 and 7 free, so the bench can drive out-of-range lookups and writes through the ports. The full 32-bit datapath lets a base near the top of the address space wrap when the offset is added. The 12-bit shift lets a 16-bit limit cover offsets up to 0x0FFF_FFFF, so the bench probes both sides of the byte limit and of the page limit.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W  = 32;
  localparam int LIMIT_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic               gran;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int IDX_W    = $clog2(NUM_SEGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  seg_desc_t        wr_desc_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output seg_desc_t        rd_desc_o,
  output logic             rd_loaded_o,
  output logic             rd_in_range_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SEGS - 1);

  seg_desc_t             entry_q [NUM_SEGS];
  logic [NUM_SEGS-1:0]   loaded_q;

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[i]  <= '0;
        loaded_q[i] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        entry_q[i]  <= wr_desc_i;
        loaded_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_desc_o   = '0;
    rd_loaded_o = 1'b0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        rd_desc_o   = entry_q[i];
        rd_loaded_o = loaded_q[i];
      end
    end
  end

  assign rd_in_range_o = (rd_idx_i <= IDX_LAST);

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i > IDX_LAST) |=> $stable(loaded_q)); // R10

  AST_WRITE_MARKS_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i <= IDX_LAST) |=> (loaded_q[$past(wr_idx_i)] == 1'b1)); // R9
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlate_pkg::*;
#(
  parameter int GRAN_SHIFT = 12
) (
  input  seg_desc_t         desc_i,
  input  logic              loaded_i,
  input  logic              in_range_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] max_ofs;

  always_comb begin
    if (desc_i.gran) max_ofs = (ADDR_W'(desc_i.limit) << GRAN_SHIFT) | PAGE_MASK;
    else             max_ofs = ADDR_W'(desc_i.limit);
  end

  assign ok_o   = in_range_i && loaded_i && (ofs_i <= max_ofs);
  assign addr_o = desc_i.base + ofs_i;

  always_comb begin
    if (in_range_i && loaded_i && !desc_i.gran && ofs_i > ADDR_W'(desc_i.limit))
      AST_BYTE_LIMIT_FAULT: assert (!ok_o); // R4
    if (in_range_i && loaded_i && desc_i.gran && ofs_i[GRAN_SHIFT-1:0] == '1 &&
        (ofs_i >> GRAN_SHIFT) == ADDR_W'(desc_i.limit))
      AST_PAGE_LIMIT_EDGE_OK: assert (ok_o); // R5
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS   = 6,
  parameter int GRAN_SHIFT = 12,
  parameter int IDX_W      = $clog2(NUM_SEGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_base_i,
  input  logic [15:0]       wr_limit_i,
  input  logic              wr_gran_i,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [31:0]       req_ofs_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [31:0]       rsp_addr_o
);
  seg_desc_t         wr_desc;
  seg_desc_t         rd_desc;
  logic              rd_loaded;
  logic              rd_in_range;
  logic              chk_ok;
  logic [ADDR_W-1:0] chk_addr;
  logic              armed_q;

  assign wr_desc = '{base: wr_base_i, limit: wr_limit_i, gran: wr_gran_i};

  seg_desc_bank #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_desc_i     (wr_desc),
    .rd_idx_i      (req_idx_i),
    .rd_desc_o     (rd_desc),
    .rd_loaded_o   (rd_loaded),
    .rd_in_range_o (rd_in_range)
  );

  seg_limit_check #(.GRAN_SHIFT(GRAN_SHIFT)) u_check (
    .desc_i     (rd_desc),
    .loaded_i   (rd_loaded),
    .in_range_i (rd_in_range),
    .ofs_i      (req_ofs_i),
    .ok_o       (chk_ok),
    .addr_o     (chk_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && chk_ok;
      rsp_fault_o <= req_valid_i && !chk_ok;
      rsp_addr_o  <= (req_valid_i && chk_ok) ? chk_addr : '0;
    end
  end

  // one cycle out of reset before $past-based checks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((rsp_valid_o || rsp_fault_o) == $past(req_valid_i))); // R2

  AST_VALID_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_fault_o)); // R6

  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_addr_o == '0)); // R6

  AST_UNLOADED_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && req_valid_i && !rd_loaded) |=> rsp_fault_o); // R7

  AST_BAD_IDX_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && req_valid_i && req_idx_i >= IDX_W'(NUM_SEGS)) |=> rsp_fault_o); // R8
endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [15:0] wr_limit = '0;
  logic        wr_gran = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_ofs = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [31:0] m_base [6];
  logic [15:0] m_limit [6];
  logic        m_gran [6];
  bit          m_loaded [6];

  logic        exp_valid = 1'b0;
  logic        exp_fault = 1'b0;
  logic [31:0] exp_addr = '0;
  string       exp_tag = "R2";

  always #10 clk = ~clk;

  seg_xlate_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_base_i(wr_base),
    .wr_limit_i(wr_limit), .wr_gran_i(wr_gran),
    .req_valid_i(req_valid), .req_idx_i(req_idx), .req_ofs_i(req_ofs),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_addr_o(rsp_addr)
  );

  task automatic compare(string tag, logic v, logic f, logic [31:0] a);
    checks++;
    if (rsp_valid !== v || rsp_fault !== f || rsp_addr !== a) begin
      fails++;
      $display("FAIL %s: got valid=%0b fault=%0b addr=%08h, expected valid=%0b fault=%0b addr=%08h",
               tag, rsp_valid, rsp_fault, rsp_addr, v, f, a);
    end
  endtask

  // One clock: check previous result, drive new inputs, predict, update model.
  task automatic cyc(bit we, int wi, logic [31:0] wb, logic [15:0] wl, bit wg,
                     bit re, int ri, logic [31:0] ro, string tag);
    logic [31:0] max_ofs;
    bit ok;
    @(negedge clk);
    compare(exp_tag, exp_valid, exp_fault, exp_addr);
    wr_en = we; wr_idx = 3'(wi); wr_base = wb; wr_limit = wl; wr_gran = wg;
    req_valid = re; req_idx = 3'(ri); req_ofs = ro;
    ok = 1'b0;
    if (ri < 6 && m_loaded[ri]) begin
      max_ofs = m_gran[ri] ? ({16'h0, m_limit[ri]} * 32'd4096 + 32'd4095) : {16'h0, m_limit[ri]};
      ok = (ro <= max_ofs);
    end
    exp_valid = re && ok;
    exp_fault = re && !ok;
    exp_addr  = (re && ok) ? m_base[ri] + ro : 32'h0;
    exp_tag   = tag;
    if (we && wi < 6) begin
      m_base[wi] = wb; m_limit[wi] = wl; m_gran[wi] = wg; m_loaded[wi] = 1'b1;
    end
  endtask

  task automatic rd(int ri, logic [31:0] ro, string tag);
    cyc(0, 0, 32'h0, 16'h0, 0, 1, ri, ro, tag);
  endtask

  task automatic wr(int wi, logic [31:0] wb, logic [15:0] wl, bit wg, string tag);
    cyc(1, wi, wb, wl, wg, 0, 0, 32'h0, tag);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_gran[i] = 1'b0; m_loaded[i] = 1'b0;
    end
    repeat (3) begin
      @(negedge clk);
      compare("R1", 1'b0, 1'b0, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 1'b0, 1'b0, 32'h0);

    // R7: nothing loaded yet
    for (int i = 0; i < 6; i++) rd(i, 32'h0, "R7");

    wr(0, 32'h1000_0000, 16'h00FF, 0, "R9");
    wr(1, 32'hFFFF_F000, 16'h0010, 1, "R9");
    wr(2, 32'h0000_0000, 16'hFFFF, 1, "R9");
    wr(5, 32'h8000_0000, 16'h0000, 0, "R9");
    rd(3, 32'h0, "R7");

    rd(0, 32'h0000_0010, "R3");
    rd(0, 32'h0000_00FF, "R4");
    rd(0, 32'h0000_0100, "R4");
    rd(5, 32'h0, "R4");
    rd(5, 32'h1, "R4");
    rd(1, 32'h0001_0FFF, "R5");
    rd(1, 32'h0001_1000, "R5");
    rd(2, 32'h0FFF_FFFF, "R5");
    rd(2, 32'h1000_0000, "R6");
    rd(1, 32'h0000_1000, "R3");

    rd(6, 32'h0, "R8");
    rd(7, 32'h0, "R8");
    wr(6, 32'h1234_0000, 16'hFFFF, 1, "R10");
    wr(7, 32'h1234_0000, 16'hFFFF, 1, "R10");
    rd(6, 32'h0, "R10");
    rd(7, 32'h5, "R10");
    for (int i = 0; i < 6; i++) rd(i, 32'h0, "R10");

    // R2: idle cycles give no response
    cyc(0, 0, 32'h0, 16'h0, 0, 0, 0, 32'h0, "R2");
    cyc(0, 0, 32'h0, 16'h0, 0, 0, 0, 32'h0, "R2");

    // R9: write and lookup at the same edge on slot 0
    cyc(1, 0, 32'h2000_0000, 16'h0000, 0, 1, 0, 32'h50, "R9");
    rd(0, 32'h50, "R9");
    rd(0, 32'h0, "R9");

    // mixed traffic against the model
    begin
      logic [31:0] lf = 32'hACE1_2345;
      for (int n = 0; n < 300; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[3:0] == 4'h0)
          cyc(1, int'(lf[6:4]), lf ^ 32'h5A5A_0000, lf[23:8], lf[9], lf[10], int'(lf[13:11]),
              {12'h0, lf[31:12]}, "R3");
        else
          cyc(0, 0, 32'h0, 16'h0, 0, lf[4] | lf[5], int'(lf[8:6]) % 8,
              lf[11] ? {16'h0, lf[31:16]} : {4'h0, lf[31:4]}, "R3");
      end
    end
    cyc(0, 0, 32'h0, 16'h0, 0, 0, 0, 32'h0, "R2");
    @(negedge clk);
    compare(exp_tag, exp_valid, exp_fault, exp_addr);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule